// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is the serial front end of a register bank that holds words of DATA_W bits (16 by default). It listens on a two-wire bus (SCL, SDA) as a slave only. It drives SDA through an open-drain enable and never drives SCL. The 7-bit slave address is built from two address pins. Each pin is wired to ground, to supply, to SDA or to SCL, and the pin state arrives already encoded as a 2-bit code. The codes are taken again at every START, so a board change applies from the next transaction.

A write transaction carries the address byte, a pointer byte and then the data word, most significant byte first. The word goes to the register bank as a one-cycle write strobe. A read transaction returns the register selected by the last pointer written. The pointer survives across transactions, so a register can be polled without writing the pointer again.

A counter running on the system clock watches SCL. If SCL stays low longer than the set timeout (28 ms by default, worked out from the clock rate), the interface drops back to idle and lets go of SDA.

Top module: `twi_ptr_slave`

## Requirements
- R1: The slave answers only the address {1,0,0,H1,H0,L1,L0}, where H is the code on addr_pin_hi and L is the code on addr_pin_lo (00 ground, 01 supply, 10 SDA, 11 SCL). For any other address it gives no ACK and does not pull SDA for the rest of the transaction.
- R2: The pin codes are sampled at each START. Changing them during a transaction has no effect until the next START.
- R3: In a write, the slave ACKs the address byte (R/W bit 0), the pointer byte and both data bytes. After the second data byte it raises reg_wr_en for one cycle, with reg_ptr equal to the pointer and reg_wr_data equal to {first byte, second byte}.
- R4: A write that stops after the pointer byte updates reg_ptr and produces no write strobe.
- R5: A read (R/W bit 1) returns reg_rd_data at the current pointer, high byte first. The pointer is kept across transactions, so repeated reads return the same register.
- R6: After the master NACKs a read byte, the slave releases SDA and sends nothing more until the next START.
- R7: When the master ACKs the low byte, the slave continues with the high byte of the same register.
- R8: Data bytes that follow a complete word in a write are not acknowledged and cause no write.
- R9: A repeated START restarts address reception without a STOP and keeps the pointer.
- R10: A STOP returns the slave to idle with SDA released. A write cut short by a STOP writes nothing.
- R11: If SCL stays low for the timeout count, the slave goes idle and releases SDA, and later transactions work normally.
- R12: The slave starts pulling SDA low only while SCL is low.
- R13: After reset, SDA is released, reg_wr_en is low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_pin_hi | input | 2 | Encoded state of the upper address pin |
| addr_pin_lo | input | 2 | Encoded state of the lower address pin |
| reg_ptr | output | PTR_W | Register pointer, used for both reads and writes |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | DATA_W | Word to write |
| reg_rd_data | input | DATA_W | Word at reg_ptr from the register bank |

## Verification
Corruption of the pointer or of the shift state shows up at the ports within one transaction. It appears as a wrong reg_ptr on the next write strobe, or as wrong bits in the next read byte. A wrong ACK phase or a stuck SDA drive shows up within one bit time: an ACK slot samples high, or a START or STOP is missed on the following transaction. A timeout that is missing or fires early shows up as SDA still held after the stall, or as a normal transaction that fails.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_PTR,
    S_WDAT,
    S_ACK,
    S_RDAT,
    S_RACK,
    S_RLOAD
  } twi_state_e;

  // Fixed upper bits 100, then the two encoded pin states.
  function automatic logic [6:0] slave_addr(input logic [1:0] hi_code,
                                            input logic [1:0] lo_code);
    return {3'b100, hi_code, lo_code};
  endfunction

  // Number of system clocks in a timeout window.
  function automatic int unsigned tmo_cycles(input int unsigned clk_khz,
                                             input int unsigned window_ms);
    return clk_khz * window_ms;
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_s, sda_s;
  logic       scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_d <= scl_s[1];
      sda_d <= sda_s[1];
    end
  end

  assign scl_q     = scl_s[1];
  assign sda_q     = sda_s[1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;

endmodule

// File: rtl/twi_timeout.sv
module twi_timeout #(
  parameter int unsigned LIMIT = 1400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_q,
  output logic tmo_hit
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      low_cnt <= '0;
    else if (scl_q)                  low_cnt <= '0;
    else if (low_cnt != CW'(LIMIT))  low_cnt <= low_cnt + CW'(1);
  end

  assign tmo_hit = !scl_q && (low_cnt == CW'(LIMIT - 1));

  // R11: one pulse per stall
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> !tmo_hit);

endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm #(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_q,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              tmo_hit,
  input  logic [1:0]        pin_hi,
  input  logic [1:0]        pin_lo,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  ptr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data
);
  import twi_pkg::*;

  localparam int NBYTES = DATA_W / 8;
  localparam int BIW    = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  twi_state_e        state, ack_next;
  logic [3:0]        bit_cnt;
  logic [7:0]        rx_sh, tx_sh;
  logic [BIW-1:0]    byte_idx;
  logic [DATA_W-1:0] wacc;
  logic [6:0]        my_addr;
  logic [PTR_W-1:0]  ptr_q;
  logic              sda_oe_q, wr_en_q;
  logic [DATA_W-1:0] wr_data_q;
  logic [7:0]        cur_byte;
  logic              last_byte;

  function automatic logic [7:0] pick_byte(input logic [DATA_W-1:0] w,
                                           input logic [BIW-1:0] idx);
    logic [DATA_W-1:0] s;
    s = w >> (8 * (NBYTES - 1 - int'(idx)));
    return s[7:0];
  endfunction

  assign cur_byte  = pick_byte(rd_data, byte_idx);
  assign last_byte = (byte_idx == BIW'(NBYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ack_next  <= S_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      byte_idx  <= '0;
      wacc      <= '0;
      my_addr   <= '0;
      ptr_q     <= '0;
      sda_oe_q  <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (tmo_hit) begin
        state    <= S_IDLE;
        sda_oe_q <= 1'b0;
      end else if (start_det) begin
        state    <= S_ADDR;
        bit_cnt  <= '0;
        sda_oe_q <= 1'b0;
        my_addr  <= slave_addr(pin_hi, pin_lo);
      end else if (stop_det) begin
        state    <= S_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_PTR, S_WDAT: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              rx_sh   <= {rx_sh[6:0], sda_q};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (state == S_ADDR) begin
                if (rx_sh[7:1] == my_addr) begin
                  sda_oe_q <= 1'b1;
                  state    <= S_ACK;
                  ack_next <= rx_sh[0] ? S_RDAT : S_PTR;
                  byte_idx <= '0;
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_PTR) begin
                ptr_q    <= rx_sh[PTR_W-1:0];
                sda_oe_q <= 1'b1;
                state    <= S_ACK;
                ack_next <= S_WDAT;
                byte_idx <= '0;
                wacc     <= '0;
              end else begin
                wacc     <= {wacc[DATA_W-9:0], rx_sh};
                sda_oe_q <= 1'b1;
                state    <= S_ACK;
                if (last_byte) begin
                  wr_en_q   <= 1'b1;
                  wr_data_q <= {wacc[DATA_W-9:0], rx_sh};
                  ack_next  <= S_IDLE;
                end else begin
                  byte_idx <= byte_idx + BIW'(1);
                  ack_next <= S_WDAT;
                end
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              state   <= ack_next;
              bit_cnt <= '0;
              if (ack_next == S_RDAT) begin
                tx_sh    <= {cur_byte[6:0], 1'b0};
                sda_oe_q <= ~cur_byte[7];
              end else begin
                sda_oe_q <= 1'b0;
              end
            end
          end
          S_RDAT: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe_q <= 1'b0;
                state    <= S_RACK;
                bit_cnt  <= '0;
              end else begin
                sda_oe_q <= ~tx_sh[7];
                tx_sh    <= {tx_sh[6:0], 1'b0};
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              if (sda_q) begin
                state <= S_IDLE;
              end else begin
                state    <= S_RLOAD;
                byte_idx <= last_byte ? '0 : byte_idx + BIW'(1);
              end
            end
          end
          S_RLOAD: begin
            if (scl_fall) begin
              tx_sh    <= {cur_byte[6:0], 1'b0};
              sda_oe_q <= ~cur_byte[7];
              state    <= S_RDAT;
              bit_cnt  <= '0;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign sda_oe  = sda_oe_q;
  assign ptr     = ptr_q;
  assign wr_en   = wr_en_q;
  assign wr_data = wr_data_q;

  // R12: a new SDA pull starts only while SCL is low
  a_r12_pull_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_q) |-> !scl_q);

  // R11: a timeout leaves the slave idle and silent
  a_r11_tmo_release: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (state == S_IDLE && !sda_oe_q));

  // R10: a STOP ends the transaction
  a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !tmo_hit) |=> (state == S_IDLE && !sda_oe_q));

  // R3: a write strobe comes with the ACK of the last data byte
  a_r3_wr_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> (sda_oe_q && state == S_ACK));

  // R5: the pointer cannot move while read data is going out
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RDAT) |=> $stable(ptr_q));

endmodule

// File: rtl/twi_ptr_slave.sv
module twi_ptr_slave #(
  parameter int unsigned CLK_KHZ    = 50000,
  parameter int unsigned TIMEOUT_MS = 28,
  parameter int          PTR_W      = 8,
  parameter int          DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_pin_hi,
  input  logic [1:0]        addr_pin_lo,
  output logic [PTR_W-1:0]  reg_ptr,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wr_data,
  input  logic [DATA_W-1:0] reg_rd_data
);
  localparam int unsigned TMO = twi_pkg::tmo_cycles(CLK_KHZ, TIMEOUT_MS);

  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det, tmo_hit;

  twi_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_timeout #(.LIMIT(TMO)) u_tmo (
    .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .tmo_hit(tmo_hit)
  );

  twi_slave_fsm #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .tmo_hit(tmo_hit),
    .pin_hi(addr_pin_hi), .pin_lo(addr_pin_lo), .rd_data(reg_rd_data),
    .sda_oe(sda_oe), .ptr(reg_ptr), .wr_en(reg_wr_en), .wr_data(reg_wr_data)
  );

endmodule

// File: tb/twi_ptr_slave_bench.sv
module twi_ptr_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int TMO        = 280;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0]  pin_hi = 2'b00, pin_lo = 2'b00;
  logic        sda_oe, reg_wr_en;
  logic [7:0]  reg_ptr;
  logic [15:0] reg_wr_data, reg_rd_data;
  wire         sda_line = sda_m & ~sda_oe;

  logic [15:0] rf [16];
  int          wr_cnt;
  logic [7:0]  last_addr;
  logic [15:0] last_data;
  int          n_chk = 0, n_bad = 0, viol = 0;
  logic        oe_d = 1'b0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_ptr_slave #(.CLK_KHZ(10), .TIMEOUT_MS(28)) u_twi_ptr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_pin_hi(pin_hi), .addr_pin_lo(pin_lo), .reg_ptr(reg_ptr),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data)
  );

  assign reg_rd_data = rf[reg_ptr[3:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) rf[i] <= 16'(i * 16'h0101);
      wr_cnt <= 0; last_addr <= '0; last_data <= '0;
    end else if (reg_wr_en) begin
      rf[reg_ptr[3:0]] <= reg_wr_data;
      wr_cnt    <= wr_cnt + 1;
      last_addr <= reg_ptr;
      last_data <= reg_wr_data;
    end
  end

  // R12 monitor: a new pull while SCL is high is a violation
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_d && scl_m) viol++;
    oe_d <= sda_oe;
  end

  // vector: {pin_hi, pin_lo, pointer, data}
  localparam logic [27:0] VEC [6] = '{
    28'h0_00_BEEF, 28'h1_03_1234, 28'h6_0F_8001,
    28'hB_07_00FF, 28'hF_0C_FFFF, 28'hC_05_7E00
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; wt(); sda_m = 0; wt(); scl_m = 0; wt();
  endtask

  task automatic bus_rstart();
    sda_m = 1; wt(); scl_m = 1; wt(); sda_m = 0; wt(); scl_m = 0; wt();
  endtask

  task automatic bus_stop();
    sda_m = 0; wt(); scl_m = 1; wt(); sda_m = 1; wt();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(); scl_m = 1; wt(); scl_m = 0; wt();
    end
    sda_m = 1; wt(); scl_m = 1; wt(); ack = !sda_line; scl_m = 0; wt();
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit ack);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wt(); scl_m = 1; wt(); b[i] = sda_line; scl_m = 0;
    end
    wt(); sda_m = ~ack; wt(); scl_m = 1; wt(); scl_m = 0; wt(); sda_m = 1;
  endtask

  function automatic logic [6:0] exp_addr(input logic [1:0] h, input logic [1:0] l);
    return {1'b1, 2'b00, h, l};
  endfunction

  task automatic write_word(input logic [6:0] a, input logic [7:0] p,
                            input logic [15:0] d, output bit all_ack);
    bit k;
    all_ack = 1;
    bus_start();
    send_byte({a, 1'b0}, k); all_ack &= k;
    send_byte(p, k);         all_ack &= k;
    send_byte(d[15:8], k);   all_ack &= k;
    send_byte(d[7:0], k);    all_ack &= k;
    bus_stop();
  endtask

  task automatic set_ptr(input logic [6:0] a, input logic [7:0] p);
    bit k;
    bus_start(); send_byte({a, 1'b0}, k); send_byte(p, k); bus_stop();
  endtask

  task automatic read_word(input logic [6:0] a, output logic [15:0] d);
    bit k;
    logic [7:0] hi, lo;
    bus_start(); send_byte({a, 1'b1}, k);
    recv_byte(hi, 1); recv_byte(lo, 0);
    bus_stop();
    d = {hi, lo};
  endtask

  initial begin
    bit          ak;
    int          prev;
    logic [15:0] rd;
    logic [7:0]  b0, b1, b2;

    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R13 sda released", sda_oe, 0);
    chk("R13 no write",     reg_wr_en, 0);
    chk("R13 pointer zero", reg_ptr, 0);

    // vector loop: R1 address forms, R3 write, R5 read back
    for (int v = 0; v < 6; v++) begin
      logic [6:0] a;
      pin_hi = VEC[v][27:26]; pin_lo = VEC[v][25:24];
      a = exp_addr(VEC[v][27:26], VEC[v][25:24]);
      prev = wr_cnt;
      write_word(a, VEC[v][23:16], VEC[v][15:0], ak);
      chk("R1 R3 all bytes acked", ak, 1);
      chk("R3 write word", {8'(wr_cnt - prev), last_addr, last_data},
          {8'd1, VEC[v][23:16], VEC[v][15:0]});
      set_ptr(a, VEC[v][23:16]);
      read_word(a, rd);
      chk("R5 read back", rd, VEC[v][15:0]);
    end
    pin_hi = 2'b00; pin_lo = 2'b00;

    // R1 mismatch
    pin_hi = 2'b01; pin_lo = 2'b10;
    prev = wr_cnt;
    bus_start();
    send_byte({7'h40, 1'b0}, ak); chk("R1 wrong address no ack", ak, 0);
    send_byte(8'h02, ak);         chk("R1 silent after mismatch", ak, 0);
    bus_stop();
    chk("R1 no write on mismatch", wr_cnt - prev, 0);
    pin_hi = 2'b00; pin_lo = 2'b00;

    // R4 pointer-only write
    prev = wr_cnt;
    set_ptr(7'h40, 8'h09);
    chk("R4 pointer updated", reg_ptr, 8'h09);
    chk("R4 no write strobe", wr_cnt - prev, 0);

    // R5 pointer retained over two reads
    read_word(7'h40, rd); chk("R5 first read", rd, 16'h0909);
    read_word(7'h40, rd); chk("R5 repeat read", rd, 16'h0909);

    // R6 NACK ends the read
    bus_start(); send_byte({7'h40, 1'b1}, ak);
    recv_byte(b0, 0); recv_byte(b1, 0);
    bus_stop();
    chk("R6 byte before nack", b0, 8'h09);
    chk("R6 silent after nack", b1, 8'hFF);

    // R7 read continues high byte after low byte
    rf[9] = rf[9]; // untouched
    bus_start(); send_byte({7'h40, 1'b1}, ak);
    recv_byte(b0, 1); recv_byte(b1, 1); recv_byte(b2, 0);
    bus_stop();
    chk("R7 wrap sequence", {b0, b1, b2}, 24'h090909);

    // R8 bytes beyond the word
    prev = wr_cnt;
    bus_start();
    send_byte({7'h40, 1'b0}, ak); send_byte(8'h0A, ak);
    send_byte(8'hAB, ak); send_byte(8'hCD, ak);
    send_byte(8'hEF, ak); chk("R8 extra byte not acked", ak, 0);
    bus_stop();
    chk("R8 single write", {8'(wr_cnt - prev), last_addr, last_data}, {8'd1, 8'h0A, 16'hABCD});

    // R10 STOP in the middle of a write
    prev = wr_cnt;
    bus_start();
    send_byte({7'h40, 1'b0}, ak); send_byte(8'h0B, ak); send_byte(8'h55, ak);
    bus_stop();
    chk("R10 no partial write", wr_cnt - prev, 0);
    chk("R10 released after stop", {reg_ptr, 7'd0, sda_oe}, {8'h0B, 8'h00});

    // R2 pins sampled at START only
    bus_start();
    pin_hi = 2'b11; pin_lo = 2'b11;
    send_byte({7'h40, 1'b0}, ak); chk("R2 old pins still apply", ak, 1);
    send_byte(8'h0C, ak);
    bus_stop();
    bus_start();
    send_byte({7'h40, 1'b0}, ak); chk("R2 new pins after start", ak, 0);
    bus_stop();
    pin_hi = 2'b00; pin_lo = 2'b00;

    // R9 repeated START keeps pointer
    bus_start();
    send_byte({7'h40, 1'b0}, ak); send_byte(8'h07, ak);
    bus_rstart();
    send_byte({7'h40, 1'b1}, ak); chk("R9 ack after repeated start", ak, 1);
    recv_byte(b0, 1); recv_byte(b1, 0);
    bus_stop();
    chk("R9 read after repeated start", {b0, b1}, 16'h00FF);
    chk("R9 pointer kept", reg_ptr, 8'h07);

    // R11 SCL stall timeout
    bus_start();
    for (int i = 7; i >= 0; i--) begin
      sda_m = (8'h80 >> (7 - i)) >> 0 == 0 ? 1'b0 : 1'b0;
      sda_m = ({7'h40, 1'b0} >> i) & 1'b1;
      wt(); scl_m = 1; wt(); scl_m = 0; wt();
    end
    sda_m = 1; wt();
    chk("R11 ack held before stall", sda_oe, 1);
    repeat (TMO + 20) @(negedge clk);
    chk("R11 released after timeout", sda_oe, 0);
    bus_stop();
    read_word(7'h40, rd);
    chk("R11 normal after timeout", rd, 16'h00FF);

    chk("R12 no pull while scl high", viol, 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule